// File: doc/BRIEF.md
# SPI Serial Clock and Chip-Select Timing Generator

This block produces the serial clock and the chip-select timing of an SPI master for one transfer at a time. A one-cycle start request latches a 32-bit attribute word and a frame-size extension bit. The block then moves through four timed phases in a fixed order. The first is a settling delay after chip select goes active. The second is the clocked data phase. The third is a hold delay after the last clock edge. The last is an idle gap with chip select released. A one-cycle completion pulse follows the gap.

The data-phase period and each of the three delays are built from a small odd prescaler multiplied by a 4-bit scaler table. The serial clock rests at the selected polarity. Two strobes, one for sampling and one for shifting, mark its edges according to the selected phase. The shift register, the FIFOs and the register bus sit outside this block and act on those strobes.

Top module: `spi_sck_timer`

## Requirements
- R1: The bit period P in system clocks is the baud prescaler value (field at bits 17:16; codes 0..3 give 2, 3, 5, 7) times the baud scaler value (bits 3:0; codes 0..3 give 2, 4, 6, 8, codes 4..15 give 2^code). Within each bit, SCK is at its active level for P/2 cycles.
- R2: Each delay lasts (2k+1)·2^(n+1) system clocks, with prescaler code k and scaler code n. The settling delay takes k from bits 23:22 and n from bits 15:12. The hold delay takes k from bits 21:20 and n from bits 11:8. The gap takes k from bits 19:18 and n from bits 7:4.
- R3: `cs_active_o` is high from the cycle after an accepted start through the settling delay, the data phase and the hold delay. It is low during the gap and while idle.
- R4: A transfer carries {extension bit, bits 30:27} + 1 bits, from 1 to 32. Exactly one sample strobe is issued per bit.
- R5: Outside the data phase, SCK rests at the polarity bit (bit 26). Its active level is the inverse of that bit.
- R6: Each bit has a leading edge (entering the active level) and a trailing edge. With the phase bit (bit 25) at 0, `sample_o` marks the leading edge and `shift_o` the trailing edge; with it at 1 the roles swap. A strobe is high in the same cycle SCK takes its new level, the two strobes are never high together, and there is one `shift_o` per bit.
- R7: `done_o` is a single-cycle pulse. It appears L+D+T+G+1 cycles after the accepting clock edge, where D = bits·P and L, T, G are the three delays.
- R8: A start request during a transfer is ignored, and so is any change of the attribute inputs. The running transfer keeps its timing, and no second transfer is queued.
- R9: While reset is asserted, SCK is low and chip select, both strobes and the completion pulse are inactive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start request, accepted only while idle |
| attr_i | input | 32 | Transfer attribute word (polarity, phase, frame size, delay and baud fields) |
| size_ext_i | input | 1 | Frame-size extension bit (most significant bit of size minus one) |
| sck_o | output | 1 | Serial clock |
| cs_active_o | output | 1 | Chip-select active window |
| sample_o | output | 1 | Sample strobe for the receive shifter |
| shift_o | output | 1 | Shift strobe for the transmit shifter |
| done_o | output | 1 | One-cycle end-of-transfer pulse |

## Verification
The assertions assume only two things about the inputs: `start_i` is a synchronous level, and the attribute word matters solely on the edge that accepts a start. They hold for any attribute value and any start pattern, including starts that land mid-transfer. The stimulus changes inputs only between clock edges. It keeps the delay and baud fields small, so full transfers finish quickly, except for one case that drives the largest baud scaler and a near-largest delay scaler.

// File: rtl/spi_sck_pkg.sv
package spi_sck_pkg;

   localparam int NUM_DLY   = 3;
   localparam int DLY_LEAD  = 0;
   localparam int DLY_TRAIL = 1;
   localparam int DLY_GAP   = 2;
   localparam int PRE_W     = 2;
   localparam int SCL_W     = 4;
   localparam int NBITS_W   = 6;

   // attribute word field positions (decoded by the register block as well)
   localparam int POS_SIZE      = 27;
   localparam int POS_CPOL      = 26;
   localparam int POS_CPHA      = 25;
   localparam int POS_LEAD_PRE  = 22;
   localparam int POS_TRAIL_PRE = 20;
   localparam int POS_GAP_PRE   = 18;
   localparam int POS_BAUD_PRE  = 16;
   localparam int POS_LEAD_SCL  = 12;
   localparam int POS_TRAIL_SCL = 8;
   localparam int POS_GAP_SCL   = 4;
   localparam int POS_BAUD_SCL  = 0;

   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_LEAD  = 3'd1,
      ST_DATA  = 3'd2,
      ST_TRAIL = 3'd3,
      ST_GAP   = 3'd4
   } phase_e;

   typedef struct packed {
      logic                               cpol;
      logic                               cpha;
      logic [NBITS_W-1:0]                 nbits;
      logic [PRE_W-1:0]                   baud_pre;
      logic [SCL_W-1:0]                   baud_scl;
      logic [NUM_DLY-1:0][PRE_W-1:0]      dly_pre;
      logic [NUM_DLY-1:0][SCL_W-1:0]      dly_scl;
   } cfg_t;

endpackage

// File: rtl/spi_sck_cfg.sv
module spi_sck_cfg
   import spi_sck_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        load_i,
   input  logic [31:0] attr_i,
   input  logic        ext_i,
   output cfg_t        cfg_o
);

   cfg_t cfg_d;
   cfg_t cfg_q;
   logic unused_attr_bits;

   assign unused_attr_bits = ^{attr_i[31], attr_i[24]};

   always_comb begin
      cfg_d                    = '0;
      cfg_d.cpol               = attr_i[POS_CPOL];
      cfg_d.cpha               = attr_i[POS_CPHA];
      cfg_d.nbits              = {1'b0, ext_i, attr_i[POS_SIZE +: 4]} + NBITS_W'(1);
      cfg_d.baud_pre           = attr_i[POS_BAUD_PRE +: PRE_W];
      cfg_d.baud_scl           = attr_i[POS_BAUD_SCL +: SCL_W];
      cfg_d.dly_pre[DLY_LEAD]  = attr_i[POS_LEAD_PRE +: PRE_W];
      cfg_d.dly_scl[DLY_LEAD]  = attr_i[POS_LEAD_SCL +: SCL_W];
      cfg_d.dly_pre[DLY_TRAIL] = attr_i[POS_TRAIL_PRE +: PRE_W];
      cfg_d.dly_scl[DLY_TRAIL] = attr_i[POS_TRAIL_SCL +: SCL_W];
      cfg_d.dly_pre[DLY_GAP]   = attr_i[POS_GAP_PRE +: PRE_W];
      cfg_d.dly_scl[DLY_GAP]   = attr_i[POS_GAP_SCL +: SCL_W];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cfg_q <= '0;
      else if (load_i) cfg_q <= cfg_d;
   end

   assign cfg_o = cfg_q;

endmodule

// File: rtl/spi_sck_len.sv
module spi_sck_len
   import spi_sck_pkg::*;
#(
   parameter int DLY_W  = 20,
   parameter int BAUD_W = 18
) (
   input  cfg_t                              cfg_i,
   output logic [NUM_DLY-1:0][DLY_W-1:0]     dly_len_o,
   output logic [BAUD_W-1:0]                 period_o,
   output logic [BAUD_W-1:0]                 half_o
);

   function automatic logic [DLY_W-1:0] dly_calc(logic [PRE_W-1:0] pre, logic [SCL_W-1:0] scl);
      logic [DLY_W-1:0] odd;
      odd = {{(DLY_W-PRE_W-1){1'b0}}, pre, 1'b1};
      return odd << ({1'b0, scl} + 5'd1);
   endfunction

   function automatic logic [BAUD_W-1:0] baud_calc(logic [PRE_W-1:0] pre, logic [SCL_W-1:0] scl);
      logic [BAUD_W-1:0] p;
      logic [BAUD_W-1:0] s;
      case (pre)
         2'd0:    p = BAUD_W'(2);
         2'd1:    p = BAUD_W'(3);
         2'd2:    p = BAUD_W'(5);
         default: p = BAUD_W'(7);
      endcase
      if (scl < 4'd4) s = BAUD_W'({scl, 1'b0}) + BAUD_W'(2);
      else            s = BAUD_W'(1) << scl;
      return p * s;
   endfunction

   for (genvar g = 0; g < NUM_DLY; g++) begin : g_dly
      assign dly_len_o[g] = dly_calc(cfg_i.dly_pre[g], cfg_i.dly_scl[g]);
   end

   assign period_o = baud_calc(cfg_i.baud_pre, cfg_i.baud_scl);
   assign half_o   = period_o >> 1;

endmodule

// File: rtl/spi_sck_bitclk.sv
module spi_sck_bitclk #(
   parameter int BAUD_W = 18,
   parameter int BITS_W = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en_i,
   input  logic [BAUD_W-1:0] period_i,
   input  logic [BAUD_W-1:0] half_i,
   input  logic [BITS_W-1:0] nbits_i,
   output logic              act_o,
   output logic              lead_edge_o,
   output logic              trail_edge_o,
   output logic              last_o
);

   logic [BAUD_W-1:0] ph_q;
   logic [BITS_W-1:0] bit_q;
   logic              ph_wrap;

   assign ph_wrap = (ph_q == period_i - BAUD_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph_q  <= '0;
         bit_q <= '0;
      end else if (!en_i) begin
         ph_q  <= '0;
         bit_q <= '0;
      end else if (ph_wrap) begin
         ph_q  <= '0;
         bit_q <= bit_q + BITS_W'(1);
      end else begin
         ph_q  <= ph_q + BAUD_W'(1);
      end
   end

   assign act_o        = en_i && (ph_q < half_i);
   assign lead_edge_o  = en_i && (ph_q == '0);
   assign trail_edge_o = en_i && (ph_q == half_i);
   assign last_o       = en_i && ph_wrap && (bit_q == nbits_i - BITS_W'(1));

endmodule

// File: rtl/spi_sck_seq.sv
module spi_sck_seq
   import spi_sck_pkg::*;
#(
   parameter int DLY_W = 20
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          start_i,
   input  logic                          last_i,
   input  logic [NUM_DLY-1:0][DLY_W-1:0] dly_len_i,
   output phase_e                        state_o,
   output logic                          done_o
);

   phase_e           state_q;
   logic [DLY_W-1:0] dcnt_q;
   logic [DLY_W-1:0] cur_len;
   logic             dly_end;
   logic             done_q;

   always_comb begin
      case (state_q)
         ST_LEAD:  cur_len = dly_len_i[DLY_LEAD];
         ST_TRAIL: cur_len = dly_len_i[DLY_TRAIL];
         default:  cur_len = dly_len_i[DLY_GAP];
      endcase
   end

   assign dly_end = (dcnt_q == cur_len - DLY_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         dcnt_q  <= '0;
         done_q  <= 1'b0;
      end else begin
         done_q <= 1'b0;
         case (state_q)
            ST_IDLE: begin
               if (start_i) begin
                  state_q <= ST_LEAD;
                  dcnt_q  <= '0;
               end
            end
            ST_LEAD: begin
               if (dly_end) begin
                  state_q <= ST_DATA;
                  dcnt_q  <= '0;
               end else dcnt_q <= dcnt_q + DLY_W'(1);
            end
            ST_DATA: begin
               if (last_i) state_q <= ST_TRAIL;
            end
            ST_TRAIL: begin
               if (dly_end) begin
                  state_q <= ST_GAP;
                  dcnt_q  <= '0;
               end else dcnt_q <= dcnt_q + DLY_W'(1);
            end
            ST_GAP: begin
               if (dly_end) begin
                  state_q <= ST_IDLE;
                  dcnt_q  <= '0;
                  done_q  <= 1'b1;
               end else dcnt_q <= dcnt_q + DLY_W'(1);
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign state_o = state_q;
   assign done_o  = done_q;

endmodule

// File: rtl/spi_sck_timer.sv
module spi_sck_timer
   import spi_sck_pkg::*;
#(
   parameter int DLY_W  = 20,
   parameter int BAUD_W = 18
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        start_i,
   input  logic [31:0] attr_i,
   input  logic        size_ext_i,
   output logic        sck_o,
   output logic        cs_active_o,
   output logic        sample_o,
   output logic        shift_o,
   output logic        done_o
);

   localparam int MIN_DLY_W  = 19;   // 7 * 2^16 needs 19 bits
   localparam int MIN_BAUD_W = 18;   // 7 * 2^15 needs 18 bits

   if (DLY_W < MIN_DLY_W) begin : g_bad_dly
      $error("spi_sck_timer: DLY_W too small for largest delay");
   end
   if (BAUD_W < MIN_BAUD_W) begin : g_bad_baud
      $error("spi_sck_timer: BAUD_W too small for largest bit period");
   end

   cfg_t                          cfg_q;
   phase_e                        state_q;
   logic [NUM_DLY-1:0][DLY_W-1:0] dly_len;
   logic [BAUD_W-1:0]             period;
   logic [BAUD_W-1:0]             half;
   logic                          act;
   logic                          lead_edge;
   logic                          trail_edge;
   logic                          last_bit;

   spi_sck_cfg u_cfg (
      .clk    (clk),
      .rst_n  (rst_n),
      .load_i (start_i && (state_q == ST_IDLE)),
      .attr_i (attr_i),
      .ext_i  (size_ext_i),
      .cfg_o  (cfg_q)
   );

   spi_sck_len #(.DLY_W(DLY_W), .BAUD_W(BAUD_W)) u_len (
      .cfg_i     (cfg_q),
      .dly_len_o (dly_len),
      .period_o  (period),
      .half_o    (half)
   );

   spi_sck_bitclk #(.BAUD_W(BAUD_W), .BITS_W(NBITS_W)) u_bitclk (
      .clk          (clk),
      .rst_n        (rst_n),
      .en_i         (state_q == ST_DATA),
      .period_i     (period),
      .half_i       (half),
      .nbits_i      (cfg_q.nbits),
      .act_o        (act),
      .lead_edge_o  (lead_edge),
      .trail_edge_o (trail_edge),
      .last_o       (last_bit)
   );

   spi_sck_seq #(.DLY_W(DLY_W)) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .start_i   (start_i),
      .last_i    (last_bit),
      .dly_len_i (dly_len),
      .state_o   (state_q),
      .done_o    (done_o)
   );

   assign sck_o       = cfg_q.cpol ^ act;
   assign sample_o    = cfg_q.cpha ? trail_edge : lead_edge;
   assign shift_o     = cfg_q.cpha ? lead_edge  : trail_edge;
   assign cs_active_o = (state_q == ST_LEAD) || (state_q == ST_DATA) || (state_q == ST_TRAIL);

endmodule

// File: rtl/spi_sck_timer_chk.sv
module spi_sck_timer_chk
   import spi_sck_pkg::*;
(
   input logic   clk,
   input logic   rst_n,
   input logic   sck_o,
   input logic   cs_active_o,
   input logic   sample_o,
   input logic   shift_o,
   input logic   done_o,
   input phase_e state_i,
   input cfg_t   cfg_i
);

   AST_SCK_RESTS_AT_POL: assert property (@(posedge clk) disable iff (!rst_n)
      (state_i != ST_DATA) |-> (sck_o == cfg_i.cpol)); // R5

   AST_STROBES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
      !(sample_o && shift_o)); // R6

   AST_STROBE_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
      (sample_o || shift_o) |-> (sck_o != $past(sck_o))); // R6

   AST_EDGE_HAS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      ((state_i == ST_DATA) && (sck_o != $past(sck_o))) |-> (sample_o || shift_o)); // R6

   AST_STROBE_IN_CS: assert property (@(posedge clk) disable iff (!rst_n)
      (sample_o || shift_o) |-> cs_active_o); // R3

   AST_DONE_CS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> !cs_active_o); // R3

   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o); // R7

   AST_CFG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      ((state_i != ST_IDLE) && ($past(state_i) != ST_IDLE)) |-> $stable(cfg_i)); // R8

endmodule

bind spi_sck_timer spi_sck_timer_chk u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .sck_o       (sck_o),
   .cs_active_o (cs_active_o),
   .sample_o    (sample_o),
   .shift_o     (shift_o),
   .done_o      (done_o),
   .state_i     (state_q),
   .cfg_i       (cfg_q)
);

// File: tb/spi_sck_timer_tb.sv
`timescale 1ns/1ps
module spi_sck_timer_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_i = 1'b0;
   logic [31:0] attr_i = '0;
   logic        size_ext_i = 1'b0;
   logic        sck_o, cs_active_o, sample_o, shift_o, done_o;

   int n_chk = 0;
   int n_fail = 0;

   always #10 clk = ~clk;   // 50 MHz

   spi_sck_timer u_dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .start_i     (start_i),
      .attr_i      (attr_i),
      .size_ext_i  (size_ext_i),
      .sck_o       (sck_o),
      .cs_active_o (cs_active_o),
      .sample_o    (sample_o),
      .shift_o     (shift_o),
      .done_o      (done_o)
   );

   // {ext, attr[31:0]} built from transfer fields
   function automatic logic [32:0] mk(int nb, bit pol, bit pha, int lp, int ls, int tp, int ts,
                                      int gp, int gs, int bp, int bs);
      logic [32:0] v;
      logic [5:0]  s;
      v = '0;
      s = 6'(nb - 1);
      v[32]    = s[4];
      v[30:27] = s[3:0];
      v[26]    = pol;
      v[25]    = pha;
      v[23:22] = 2'(lp);
      v[21:20] = 2'(tp);
      v[19:18] = 2'(gp);
      v[17:16] = 2'(bp);
      v[15:12] = 4'(ls);
      v[11:8]  = 4'(ts);
      v[7:4]   = 4'(gs);
      v[3:0]   = 4'(bs);
      return v;
   endfunction

   localparam int NVEC = 6;
   localparam logic [32:0] VEC [NVEC] = '{
      mk( 8, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0),
      mk( 8, 1, 0, 1, 1, 2, 0, 3, 1, 1, 1),
      mk(16, 0, 1, 3, 2, 0, 3, 1, 2, 2, 2),
      mk(32, 1, 1, 2, 1, 1, 2, 0, 0, 3, 3),
      mk( 1, 0, 1, 0, 0, 0, 0, 0, 0, 0, 4),
      mk(17, 0, 0, 0, 1, 0, 1, 0, 1, 3, 0)
   };

   function automatic int e_baud(int bp, int bs);
      int p;
      int s;
      p = (bp == 0) ? 2 : (bp == 1) ? 3 : (bp == 2) ? 5 : 7;
      s = (bs < 4) ? 2 * (bs + 1) : (1 << bs);
      return p * s;
   endfunction

   function automatic int e_dly(int p, int s);
      return (2 * p + 1) * (2 << s);
   endfunction

   task automatic chk(string req, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   int r_total, r_cs, r_act, r_smp, r_shf, r_lead, r_first_smp, r_idle_lvl;

   task automatic run(input logic [32:0] v, input bit poke, input logic [32:0] pv);
      int  n;
      bit  seen;
      @(negedge clk);
      attr_i = v[31:0]; size_ext_i = v[32]; start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      n = 1; seen = 0;
      r_cs = 0; r_act = 0; r_smp = 0; r_shf = 0; r_lead = -1; r_first_smp = -1;
      forever begin
         if (cs_active_o) r_cs++;
         if (sck_o != v[26]) r_act++;
         if (sample_o) r_smp++;
         if (shift_o) r_shf++;
         if (!seen && (sample_o || shift_o)) begin
            seen = 1; r_lead = n - 1; r_first_smp = sample_o ? 1 : 0;
         end
         if (done_o || n > 150000) break;
         if (poke && n == 5) begin
            start_i = 1'b1; attr_i = pv[31:0]; size_ext_i = pv[32];
         end else start_i = 1'b0;
         n++;
         @(negedge clk);
      end
      start_i = 1'b0;
      r_total = n;
      r_idle_lvl = int'(sck_o);
   endtask

   task automatic verify(input logic [32:0] v, input string tag);
      int nb, P, L, T, G;
      nb = int'({v[32], v[30:27]}) + 1;
      P  = e_baud(int'(v[17:16]), int'(v[3:0]));
      L  = e_dly(int'(v[23:22]), int'(v[15:12]));
      T  = e_dly(int'(v[21:20]), int'(v[11:8]));
      G  = e_dly(int'(v[19:18]), int'(v[7:4]));
      chk({"R7 total cycles ", tag}, r_total, L + nb * P + T + G + 1);
      chk({"R3 cs active cycles ", tag}, r_cs, L + nb * P + T);
      chk({"R2 settling delay ", tag}, r_lead, L);
      chk({"R2 gap delay ", tag}, r_total - 1 - r_cs, G);
      chk({"R1 active-level cycles ", tag}, r_act, nb * (P / 2));
      chk({"R4 sample strobes ", tag}, r_smp, nb);
      chk({"R6 shift strobes ", tag}, r_shf, nb);
      chk({"R6 first strobe is sample ", tag}, r_first_smp, v[25] ? 0 : 1);
      chk({"R5 sck rest level ", tag}, r_idle_lvl, int'(v[26]));
   endtask

   initial begin
      #(199_000 * 20);
      n_chk++; n_fail++;
      $display("FAIL R7 watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      int cnt;
      // R9: reset state
      repeat (3) @(negedge clk);
      chk("R9 outputs in reset", int'({sck_o, cs_active_o, sample_o, shift_o, done_o}), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R9 outputs after reset", int'({sck_o, cs_active_o, sample_o, shift_o, done_o}), 0);

      // table walk
      for (int i = 0; i < NVEC; i++) begin
         run(VEC[i], 1'b0, '0);
         verify(VEC[i], $sformatf("vec%0d", i));
      end

      // R8: start request and attribute change mid-transfer are ignored
      run(VEC[0], 1'b1, VEC[3]);
      verify(VEC[0], "R8 mid-transfer start");
      cnt = 0;
      for (int k = 0; k < 12; k++) begin
         @(negedge clk);
         if (cs_active_o || done_o) cnt++;
      end
      chk("R8 no queued transfer", cnt, 0);

      // R1/R2 largest baud scaler with a large settling delay
      begin
         logic [32:0] big;
         big = mk(1, 0, 0, 0, 14, 0, 0, 0, 0, 0, 15);
         run(big, 1'b0, '0);
         verify(big, "large fields");
      end

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule